// File: doc/BRIEF.md
# Ring-Walking Receive DMA Engine

This engine takes received Ethernet frames from a byte stream that marks the first and last byte of each frame. It stores them in memory buffers described by a circular chain of descriptors. Each descriptor is four 32-bit words. The engine follows the chain through explicit next pointers. For each descriptor it reads the control, link and buffer words over a single word-wide memory master port. It then packs the frame into the buffer and finishes with one status write, which marks the descriptor complete and records how many bytes arrived.

Software controls the engine through three inputs. It gives the address of the first descriptor, pulses a start input and pulses a stop input. Flow control comes from a hold flag in each descriptor's control word. A held descriptor stops the engine. The engine re-reads that word at a programmable interval until software clears the flag. Frames longer than the buffer are cut at the buffer size, and the rest of that frame is thrown away.

Top module: `rxd_dma_top`

## Requirements
- R1: After `start` while idle, the engine reads the descriptor at `ring_base`. For each descriptor it reads the control word at +0, the link word at +4 and the buffer pointer at +8, and it writes status at +12.
- R2: When a descriptor is finished, the next one is taken from its link word, so a chain whose last link points to the first is walked as a ring.
- R3: If bit 31 of the control word is set, the descriptor is not used. No stream byte is taken, nothing is written, and the control word is re-read after about `poll_gap` idle cycles until the bit reads as clear.
- R4: Frame bytes are stored little-endian from address buffer pointer + offset, where the offset is control bits 28:26 and a zero offset means the buffer pointer itself. Byte enables leave every byte outside the frame unchanged.
- R5: The status word has bit 31 = 1 (complete), bit 30 = 1 (frame start stored), bit 29 = end-of-frame stored, and bits 16:0 = the number of bytes stored, which includes the trailing 4 CRC bytes. Bits 28:17 are zero.
- R6: Control bits 21:0 give the buffer size. A longer frame stores exactly that many bytes, closes its descriptor with bit 29 of status clear, and drops its remaining bytes.
- R7: While waiting for a frame, bytes that do not carry the start marker are accepted and discarded.
- R8: The status write comes after every data write of the frame has been accepted, so when software sees bit 31 set, the whole buffer content is already in memory.
- R9: A memory request (`m_rd` or `m_wr`) keeps its address, data and enables steady until `m_ready`. The engine never reads and writes in the same cycle.
- R10: After reset the engine is idle. In that state `running`, `s_ready`, `m_rd` and `m_wr` are all low. A `stop` pulse returns it to idle at a descriptor boundary (a held descriptor or one still waiting for a frame), and a later `start` resumes from `ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: leave idle and fetch the descriptor at `ring_base` |
| stop | input | 1 | Pulse: return to idle at the next descriptor boundary |
| ring_base | input | 32 | Byte address of the first descriptor |
| poll_gap | input | 8 | Idle cycles between re-reads of a held control word |
| running | output | 1 | High whenever the engine is not idle |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_sop | input | 1 | Byte is the first of a frame |
| s_eop | input | 1 | Byte is the last of a frame |
| s_ready | output | 1 | Engine takes the stream byte this cycle |
| m_addr | output | 32 | Memory byte address (word aligned) |
| m_rd | output | 1 | Memory read request |
| m_wr | output | 1 | Memory write request |
| m_wdata | output | 32 | Memory write data |
| m_be | output | 4 | Write byte enables, bit n for bits 8n+7:8n |
| m_rdata | input | 32 | Memory read data, valid with `m_ready` |
| m_ready | input | 1 | Memory accepts the current request |

## Verification
The stimulus covers several frame shapes:

- A 64-byte frame on an aligned buffer, which shows whole-word packing.
- Short frames at odd offsets, whose leading and trailing partial words test byte enables and guard bytes.
- A frame with stray bytes before it that carry no start marker, which separates drop logic from frame capture.
- A frame that overruns its buffer, which separates truncation (bit 29 clear, count equal to the size) from normal closing.

The next frame then shows that the dropped tail did not leak into the following descriptor. A descriptor that stays held while a frame waits shows that the engine polls without consuming it. A stop and restart shows that the chain starts again from its base. Random lengths, offsets, sizes and memory stalls over many passes around the ring check ring order and how the byte count tracks the CRC-inclusive length.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;
    localparam int LEN_W      = 17;
    localparam int SIZE_W     = 22;

    // byte offsets of the four descriptor words
    localparam logic [31:0] OFS_CTRL = 32'd0;
    localparam logic [31:0] OFS_LINK = 32'd4;
    localparam logic [31:0] OFS_BUF  = 32'd8;
    localparam logic [31:0] OFS_STAT = 32'd12;

    localparam int HOLD_BIT = 31;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_CTRL,
        ST_HOLD,
        ST_RD_LINK,
        ST_RD_BUF,
        ST_WAIT_SOP,
        ST_RECV,
        ST_WR_DATA,
        ST_WR_STAT
    } rxd_state_e;

    typedef struct packed {
        logic              hold;
        logic              irq_done;
        logic              irq_eop;
        logic [2:0]        offset;
        logic [SIZE_W-1:0] max_size;
    } rxd_ctrl_t;

    typedef struct packed {
        logic             done;
        logic             sop;
        logic             eop;
        logic [LEN_W-1:0] count;
    } rxd_stat_t;

    function automatic rxd_ctrl_t decode_ctrl(input logic [WORD_W-1:0] w);
        rxd_ctrl_t c;
        c.hold     = w[31];
        c.irq_done = w[30];
        c.irq_eop  = w[29];
        c.offset   = w[28:26];
        c.max_size = w[SIZE_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] encode_stat(input rxd_stat_t s);
        return {s.done, s.sop, s.eop, 12'b0, s.count};
    endfunction

endpackage

// File: rtl/rxd_byte_packer.sv
module rxd_byte_packer #(
    parameter  int BYTES = 4,
    localparam int LW    = $clog2(BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic [LW-1:0]      lane_init,
    input  logic               push,
    input  logic [7:0]         din,
    input  logic               ack,
    output logic [8*BYTES-1:0] word,
    output logic [BYTES-1:0]   be,
    output logic [LW-1:0]      lane
);

    logic [LW-1:0] lane_q;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [7:0] byte_q;
        logic       en_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
                en_q   <= 1'b0;
            end else if (clear || ack) begin
                en_q   <= 1'b0;
            end else if (push && lane_q == LW'(g)) begin
                byte_q <= din;
                en_q   <= 1'b1;
            end
        end
        assign word[8*g +: 8] = byte_q;
        assign be[g]          = en_q;
    end

    always_ff @(posedge clk) begin
        if (rst)        lane_q <= '0;
        else if (clear) lane_q <= lane_init;
        else if (push)  lane_q <= lane_q + 1'b1;
    end

    assign lane = lane_q;

endmodule

// File: rtl/rxd_poll_timer.sv
module rxd_poll_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] gap,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= gap;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/rxd_dma_top.sv
module rxd_dma_top
    import rxd_pkg::*;
#(
    parameter  int POLL_W = 8,
    localparam int LW     = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [31:0]       ring_base,
    input  logic [POLL_W-1:0] poll_gap,
    output logic              running,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_sop,
    input  logic              s_eop,
    output logic              s_ready,
    output logic [31:0]       m_addr,
    output logic              m_rd,
    output logic              m_wr,
    output logic [WORD_W-1:0] m_wdata,
    output logic [WORD_BYTES-1:0] m_be,
    input  logic [WORD_W-1:0] m_rdata,
    input  logic              m_ready
);

    rxd_state_e        state_q;
    rxd_ctrl_t         ctrl_q;
    logic [31:0]       cur_desc;
    logic [31:0]       link_q;
    logic [31:0]       wptr_q;
    logic [LEN_W-1:0]  count_q;
    logic              eop_q;
    logic              fin_q;
    logic              stop_req;

    logic [WORD_W-1:0]     pk_word;
    logic [WORD_BYTES-1:0] pk_be;
    logic [LW-1:0]         pk_lane;
    logic                  pk_clear, pk_ack, take, tm_load, tm_done;
    logic [31:0]           buf_start;
    logic [LEN_W-1:0]      cnt_nx;
    logic                  lim_hit, word_full, closes;
    logic [SIZE_W-1:0]     cur_max;
    rxd_stat_t             stat_w;

    assign running   = (state_q != ST_IDLE);
    assign cur_max   = ctrl_q.max_size;
    assign buf_start = m_rdata + {29'b0, ctrl_q.offset};

    assign take      = s_valid && s_ready && (state_q == ST_RECV || s_sop);
    assign cnt_nx    = (state_q == ST_WAIT_SOP) ? LEN_W'(1) : count_q + 1'b1;
    assign lim_hit   = ({{(SIZE_W-LEN_W){1'b0}}, cnt_nx} >= ctrl_q.max_size) || (&cnt_nx);
    assign word_full = (pk_lane == LW'(WORD_BYTES-1));
    assign closes    = s_eop || lim_hit;

    assign pk_clear  = (state_q == ST_RD_BUF) && m_ready;
    assign pk_ack    = (state_q == ST_WR_DATA) && m_ready;
    assign tm_load   = (state_q == ST_RD_CTRL) && m_ready && m_rdata[HOLD_BIT];

    assign stat_w.done  = 1'b1;
    assign stat_w.sop   = 1'b1;
    assign stat_w.eop   = eop_q;
    assign stat_w.count = count_q;

    rxd_byte_packer #(.BYTES(WORD_BYTES)) packer_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (pk_clear),
        .lane_init (buf_start[LW-1:0]),
        .push      (take),
        .din       (s_data),
        .ack       (pk_ack),
        .word      (pk_word),
        .be        (pk_be),
        .lane      (pk_lane)
    );

    rxd_poll_timer #(.W(POLL_W)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .load (tm_load),
        .gap  (poll_gap),
        .done (tm_done)
    );

    // memory and stream handshake decode
    always_comb begin
        m_rd    = 1'b0;
        m_wr    = 1'b0;
        m_addr  = cur_desc;
        m_wdata = '0;
        m_be    = '0;
        s_ready = 1'b0;
        unique case (state_q)
            ST_RD_CTRL: begin
                m_rd   = 1'b1;
                m_addr = cur_desc + OFS_CTRL;
            end
            ST_RD_LINK: begin
                m_rd   = 1'b1;
                m_addr = cur_desc + OFS_LINK;
            end
            ST_RD_BUF: begin
                m_rd   = 1'b1;
                m_addr = cur_desc + OFS_BUF;
            end
            ST_WAIT_SOP: s_ready = !stop_req;
            ST_RECV:     s_ready = 1'b1;
            ST_WR_DATA: begin
                m_wr    = 1'b1;
                m_addr  = {wptr_q[31:LW], {LW{1'b0}}};
                m_wdata = pk_word;
                m_be    = pk_be;
            end
            ST_WR_STAT: begin
                m_wr    = 1'b1;
                m_addr  = cur_desc + OFS_STAT;
                m_wdata = encode_stat(stat_w);
                m_be    = '1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ctrl_q   <= '0;
            cur_desc <= '0;
            link_q   <= '0;
            wptr_q   <= '0;
            count_q  <= '0;
            eop_q    <= 1'b0;
            fin_q    <= 1'b0;
            stop_req <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) stop_req <= 1'b0;
            else if (stop)          stop_req <= 1'b1;

            unique case (state_q)
                ST_IDLE: if (start) begin
                    cur_desc <= ring_base;
                    state_q  <= ST_RD_CTRL;
                end
                ST_RD_CTRL: if (m_ready) begin
                    ctrl_q  <= decode_ctrl(m_rdata);
                    state_q <= m_rdata[HOLD_BIT] ? ST_HOLD : ST_RD_LINK;
                end
                ST_HOLD: begin
                    if (stop_req)     state_q <= ST_IDLE;
                    else if (tm_done) state_q <= ST_RD_CTRL;
                end
                ST_RD_LINK: if (m_ready) begin
                    link_q  <= m_rdata;
                    state_q <= ST_RD_BUF;
                end
                ST_RD_BUF: if (m_ready) begin
                    wptr_q  <= buf_start;
                    count_q <= '0;
                    eop_q   <= 1'b0;
                    fin_q   <= 1'b0;
                    state_q <= ST_WAIT_SOP;
                end
                ST_WAIT_SOP, ST_RECV: begin
                    if (state_q == ST_WAIT_SOP && stop_req) begin
                        state_q <= ST_IDLE;
                    end else if (take) begin
                        count_q <= cnt_nx;
                        eop_q   <= s_eop;
                        fin_q   <= closes;
                        state_q <= (word_full || closes) ? ST_WR_DATA : ST_RECV;
                    end
                end
                ST_WR_DATA: if (m_ready) begin
                    wptr_q  <= {wptr_q[31:LW] + 1'b1, {LW{1'b0}}};
                    state_q <= fin_q ? ST_WR_STAT : ST_RECV;
                end
                ST_WR_STAT: if (m_ready) begin
                    cur_desc <= link_q;
                    state_q  <= stop_req ? ST_IDLE : ST_RD_CTRL;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rxd_dma_chk.sv
module rxd_dma_chk
    import rxd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              running,
    input logic              s_ready,
    input logic              m_rd,
    input logic              m_wr,
    input logic              m_ready,
    input logic [31:0]       m_addr,
    input logic [WORD_W-1:0] m_wdata,
    input logic [WORD_W-1:0] m_rdata,
    input logic [WORD_BYTES-1:0] m_be,
    input logic [31:0]       cur_desc,
    input logic [SIZE_W-1:0] cur_max
);

    logic stat_wr;
    assign stat_wr = m_wr && (m_addr == cur_desc + OFS_STAT);

    assert_rw_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(m_rd && m_wr));

    assert_req_steady_R9: assert property (@(posedge clk) disable iff (rst)
        (m_rd || m_wr) && !m_ready |=>
            (m_rd == $past(m_rd)) && (m_wr == $past(m_wr)) &&
            $stable(m_addr) && $stable(m_wdata) && $stable(m_be));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !running |-> !s_ready && !m_rd && !m_wr);

    assert_stat_format_R5: assert property (@(posedge clk) disable iff (rst)
        stat_wr |-> m_wdata[31] && m_wdata[30] && (m_wdata[28:17] == 12'b0) && (m_be == '1));

    assert_trunc_limit_R6: assert property (@(posedge clk) disable iff (rst)
        stat_wr |-> ({5'b0, m_wdata[16:0]} <= cur_max) &&
                    (m_wdata[29] || ({5'b0, m_wdata[16:0]} == cur_max)));

    assert_hold_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        m_rd && m_ready && (m_addr == cur_desc + OFS_CTRL) && m_rdata[HOLD_BIT] |=>
            !s_ready && !m_wr);

    assert_be_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        m_wr |-> (m_be != '0));

endmodule

bind rxd_dma_top rxd_dma_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .running  (running),
    .s_ready  (s_ready),
    .m_rd     (m_rd),
    .m_wr     (m_wr),
    .m_ready  (m_ready),
    .m_addr   (m_addr),
    .m_wdata  (m_wdata),
    .m_rdata  (m_rdata),
    .m_be     (m_be),
    .cur_desc (cur_desc),
    .cur_max  (cur_max)
);

// File: tb/rxd_dma_top_tb_top.sv
module rxd_dma_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;
    localparam logic [31:0] DESC0 = 32'h100;
    localparam logic [31:0] BUF0  = 32'h400;

    logic        clk = 1'b0;
    logic        rst, start, stop, running;
    logic [31:0] ring_base;
    logic [7:0]  poll_gap;
    logic        s_valid, s_sop, s_eop, s_ready;
    logic [7:0]  s_data;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic        m_rd, m_wr, m_ready;
    logic [3:0]  m_be;

    logic [31:0] mem [0:1023];
    logic [7:0]  fb  [0:255];
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxd_dma_top dut_i (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .ring_base(ring_base),
        .poll_gap(poll_gap), .running(running), .s_valid(s_valid), .s_data(s_data),
        .s_sop(s_sop), .s_eop(s_eop), .s_ready(s_ready), .m_addr(m_addr), .m_rd(m_rd),
        .m_wr(m_wr), .m_wdata(m_wdata), .m_be(m_be), .m_rdata(m_rdata), .m_ready(m_ready)
    );

    // memory model with random stalls
    assign m_rdata = mem[m_addr[11:2]];
    always @(posedge clk) begin
        if (rst) m_ready <= 1'b0;
        else     m_ready <= (($urandom % 4) != 0);
        if (m_wr && m_ready)
            for (int b = 0; b < 4; b++)
                if (m_be[b]) mem[m_addr[11:2]][8*b +: 8] <= m_wdata[8*b +: 8];
    end

    function automatic logic [31:0] daddr(input int i);
        return DESC0 + 32'(16 * i);
    endfunction
    function automatic logic [31:0] baddr(input int i);
        return BUF0 + 32'(256 * i);
    endfunction
    function automatic logic [7:0] rbyte(input logic [31:0] a);
        return mem[a[11:2]][8*a[1:0] +: 8];
    endfunction
    function automatic logic [31:0] exp_stat(input int len, input int mx);
        int n;
        n = (len > mx) ? mx : len;
        return {1'b1, 1'b1, (len <= mx), 12'b0, 17'(n)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic init_ring();
        for (int i = 0; i < 3; i++) begin
            mem[daddr(i)[11:2]]     = 32'h8000_0100;
            mem[daddr(i)[11:2] + 1] = daddr((i + 1) % 3);
            mem[daddr(i)[11:2] + 2] = baddr(i);
            mem[daddr(i)[11:2] + 3] = 32'h0;
        end
    endtask

    task automatic give(input int i, input int off, input int mx);
        for (int w = 0; w < 64; w++) mem[baddr(i)[11:2] + w] = 32'hA5A5_A5A5;
        mem[daddr(i)[11:2] + 3] = 32'h0;
        mem[daddr(i)[11:2]]     = {1'b0, 2'b00, 3'(off), 4'b0, 22'(mx)};
    endtask

    task automatic push_byte(input logic [7:0] b, input logic sop, input logic eop);
        logic took;
        s_valid = 1'b1; s_data = b; s_sop = sop; s_eop = eop;
        took = 1'b0;
        while (!took) begin
            took = s_ready;
            @(negedge clk);
        end
        s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
    endtask

    task automatic send_frame(input int len);
        for (int k = 0; k < len; k++) fb[k] = 8'($urandom);
        for (int k = 0; k < len; k++) push_byte(fb[k], k == 0, k == len - 1);
    endtask

    // R8: data is checked as soon as the complete bit is seen
    task automatic check_desc(input int i, input int len, input int off, input int mx);
        int n, bad;
        logic [31:0] sa, st;
        sa = daddr(i) + 32'd12;
        while (!mem[sa[11:2]][31]) @(negedge clk);
        st = mem[sa[11:2]];
        chk(st == exp_stat(len, mx), (len > mx) ? "R6 truncated status" : "R5 status word", st, exp_stat(len, mx));
        n = (len > mx) ? mx : len;
        bad = 0;
        for (int k = 0; k < n; k++)
            if (rbyte(baddr(i) + 32'(off + k)) !== fb[k]) bad++;
        chk(bad == 0, "R4/R8 buffer data", 32'(bad), 32'd0);
        bad = 0;
        if (off > 0 && rbyte(baddr(i) + 32'(off - 1)) !== 8'hA5) bad++;
        if (rbyte(baddr(i) + 32'(off + n)) !== 8'hA5) bad++;
        chk(bad == 0, "R4/R6 guard bytes", 32'(bad), 32'd0);
        mem[daddr(i)[11:2]][31] = 1'b1;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int k, off, len, mx, rd_cnt, rdy_cnt;
        bit pre;
        void'($urandom(32'd4711));
        rst = 1'b1; start = 1'b0; stop = 1'b0; ring_base = DESC0; poll_gap = 8'd7;
        s_valid = 1'b0; s_data = 8'h0; s_sop = 1'b0; s_eop = 1'b0;
        for (int w = 0; w < 1024; w++) mem[w] = 32'h0;
        init_ring();
        repeat (3) @(negedge clk);
        chk(running == 1'b0, "R10 reset running", 32'(running), 0);
        chk(s_ready == 1'b0, "R10 reset s_ready", 32'(s_ready), 0);
        chk(m_rd == 1'b0 && m_wr == 1'b0, "R10 reset memory idle", {30'b0, m_rd, m_wr}, 0);
        rst = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;

        // R1, R5: aligned 64-byte frame in descriptor 0
        give(0, 0, 200); send_frame(64); check_desc(0, 64, 0, 200);
        // R4: short frame at offset 3 in descriptor 1
        give(1, 3, 200); send_frame(5); check_desc(1, 5, 3, 200);

        // R3: descriptor 2 held while a frame waits
        fork
            send_frame(9);
            begin
                rd_cnt = 0; rdy_cnt = 0;
                for (int c = 0; c < 60; c++) begin
                    @(negedge clk);
                    if (s_ready) rdy_cnt++;
                    if (m_rd && m_ready && m_addr == daddr(2)) rd_cnt++;
                end
                chk(rdy_cnt == 0, "R3 no byte taken while held", 32'(rdy_cnt), 0);
                chk(rd_cnt >= 3, "R3 control word re-read", 32'(rd_cnt), 3);
                chk(mem[daddr(2)[11:2] + 3] == 32'h0, "R3 held status untouched", mem[daddr(2)[11:2] + 3], 0);
                give(2, 1, 200);
            end
        join
        check_desc(2, 9, 1, 200);

        // R2 wrap to descriptor 0, R7 stray bytes dropped
        give(0, 2, 200);
        for (int j = 0; j < 3; j++) push_byte(8'hEE, 1'b0, j == 2);
        send_frame(12); check_desc(0, 12, 2, 200);

        // R6 truncation, tail must not reach descriptor 2
        give(1, 0, 10); give(2, 0, 200);
        send_frame(20); check_desc(1, 20, 0, 10);
        send_frame(8);  check_desc(2, 8, 0, 200);

        // R10 stop while held at descriptor 0, then restart from base
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        repeat (12) @(negedge clk);
        chk(running == 1'b0, "R10 stop reaches idle", 32'(running), 0);
        give(0, 0, 200);
        s_valid = 1'b1; s_sop = 1'b1; s_data = 8'h11;
        rdy_cnt = 0;
        for (int c = 0; c < 20; c++) begin @(negedge clk); if (s_ready) rdy_cnt++; end
        s_valid = 1'b0; s_sop = 1'b0;
        chk(rdy_cnt == 0, "R10 idle ignores stream", 32'(rdy_cnt), 0);
        chk(mem[daddr(0)[11:2] + 3] == 32'h0, "R10 idle writes nothing", mem[daddr(0)[11:2] + 3], 0);
        init_ring();
        give(0, 1, 200);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        send_frame(7); check_desc(0, 7, 1, 200);

        // R2, R5, R6: random passes around the ring
        k = 1; pre = 1'b0;
        for (int it = 0; it < 15; it++) begin
            len = 1 + int'($urandom % 60);
            if (pre) begin
                off = 0; mx = 200; pre = 1'b0;
            end else begin
                off = int'($urandom % 8);
                mx  = (($urandom % 4) == 0) ? 1 + int'($urandom % len) : 200;
                give(k, off, mx);
            end
            if (len > mx) begin
                give((k + 1) % 3, 0, 200);
                pre = 1'b1;
            end
            send_frame(len);
            check_desc(k, len, off, mx);
            k = (k + 1) % 3;
        end
        if (pre) begin
            send_frame(4); check_desc(k, 4, 0, 200);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule